// File: doc/BRIEF.md
# Descriptor List Walker

This block decides which transfer descriptor a transaction engine should run next. Descriptors sit in three lists in a local descriptor memory. The lists are isochronous, interrupt and asynchronous, and each holds up to `N` entries. A pulse on `start` begins one pass over the lists. The pass visits the isochronous list, then the interrupt list, then the asynchronous list. Within each list it moves upward from index 0.

At each entry the walker checks that list's skip bitmap. An entry whose skip bit is clear is offered to the engine on a valid/ready issue port. Once the engine accepts the offer, the walker waits for a `done` pulse before it looks at any other entry.

The walker reads the next-pointer field of the current entry through a read port. The memory must answer that read in the same cycle. Both port sides use the same address: (`np_list`, `np_idx`) equals (`iss_list`, `iss_idx`). A valid next pointer that points forward makes the walk jump straight to its target. A pointer that does not point forward is ignored.

A list's traversal ends in one of two ways. It ends after the entry at that list's last index has been visited. It also ends when a forward pointer targets an index beyond that last index. When the asynchronous list ends, `pass_done` pulses and the walker goes idle.

Back-pressure on the issue port follows these rules:
- The walker holds `iss_valid`, `iss_list` and `iss_idx` steady until `iss_ready` is high at a clock edge.
- The transfer happens at that edge.

Top module: `dlw_walker`

## Requirements
- R1: After reset, `iss_valid` and `pass_done` are low, and no entry is offered until `start` is pulsed.
- R2: Within a pass, entries are offered in list order isochronous (code 0), then interrupt (code 1), then asynchronous (code 2) on `iss_list`. Within a list, indices strictly increase.
- R3: A list whose bit in `list_en` is low (bit 0 isochronous, bit 1 interrupt, bit 2 asynchronous) offers no entries. The pass continues with the next list.
- R4: An entry whose bit is set in its list's skip bitmap (bit k for index k) is never offered. The walk still advances past it, using the same rules as for an offered entry.
- R5: When the visited entry has `np_valid` high and `np_target` greater than its index but not greater than the list's last index, the next entry visited is `np_target`.
- R6: When `np_valid` is high and `np_target` is equal to or below the current index, the pointer is ignored and the walk moves to the next index.
- R7: When `np_valid` is high and `np_target` is beyond the list's last index, traversal of that list ends.
- R8: With no valid forward pointer, a list ends after its entry at the last index has been visited. No offered index exceeds the last index.
- R9: While `iss_valid` is high and `iss_ready` is low, `iss_valid`, `iss_list` and `iss_idx` hold their values into the next cycle.
- R10: After an offer is accepted, `iss_valid` stays low until a `done` pulse arrives.
- R11: When the last list of a pass ends, `pass_done` is high for exactly one cycle. It is raised even when every list is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass (sampled while idle) |
| list_en | input | 3 | Per-list enable: bit 0 isochronous, bit 1 interrupt, bit 2 asynchronous |
| skip_iso | input | N | Isochronous skip bitmap |
| skip_int | input | N | Interrupt skip bitmap |
| skip_asy | input | N | Asynchronous skip bitmap |
| last_iso | input | log2(N) | Isochronous last index |
| last_int | input | log2(N) | Interrupt last index |
| last_asy | input | log2(N) | Asynchronous last index |
| np_list | output | 2 | Next-pointer read: list of current entry |
| np_idx | output | log2(N) | Next-pointer read: index of current entry |
| np_valid | input | 1 | Current entry holds a next pointer |
| np_target | input | log2(N) | Next-pointer target index |
| iss_valid | output | 1 | An entry is offered to the engine |
| iss_ready | input | 1 | Engine accepts the offer |
| iss_list | output | 2 | List code of the offered entry |
| iss_idx | output | log2(N) | Index of the offered entry |
| done | input | 1 | Engine finished the accepted entry |
| pass_done | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The hardest situations to reach from the ports are those where several walk rules act on the same entry. Examples are a skipped entry whose forward pointer lands exactly on the last index, and a backward pointer on the last entry of a list. An entry whose target overshoots the last index, followed by a disabled list, is another. Directed passes set up each of these by hand. A sweep then runs every one of the 256 isochronous skip patterns of an 8-entry configuration, with the other bitmaps, last indices, enables and pointer tables derived from a pseudo-random generator. Each pass is compared against a walk model computed in the bench, with varying ready and done delays.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  typedef enum logic [1:0] {
    LT_ISO  = 2'd0,
    LT_INT  = 2'd1,
    LT_ASY  = 2'd2,
    LT_NONE = 2'd3
  } list_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVAL  = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } walk_st_t;
endpackage

// File: rtl/dlw_list_sel.sv
module dlw_list_sel #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  dlw_pkg::list_t sel,
  input  logic [2:0]     list_en,
  input  logic [N-1:0]   skip_iso,
  input  logic [N-1:0]   skip_int,
  input  logic [N-1:0]   skip_asy,
  input  logic [IW-1:0]  last_iso,
  input  logic [IW-1:0]  last_int,
  input  logic [IW-1:0]  last_asy,
  output logic           en_sel,
  output logic [N-1:0]   skip_sel,
  output logic [IW-1:0]  last_sel
);
  import dlw_pkg::*;

  logic [2:0][N-1:0]  skip_all;
  logic [2:0][IW-1:0] last_all;

  assign skip_all = {skip_asy, skip_int, skip_iso};
  assign last_all = {last_asy, last_int, last_iso};

  always_comb begin
    en_sel   = 1'b0;
    skip_sel = '1;
    last_sel = '0;
    for (int k = 0; k < 3; k++) begin
      if (sel == list_t'(k)) begin
        en_sel   = list_en[k];
        skip_sel = skip_all[k];
        last_sel = last_all[k];
      end
    end
  end
endmodule

// File: rtl/dlw_advance.sv
module dlw_advance #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [IW-1:0] cur_idx,
  input  logic [IW-1:0] last_idx,
  input  logic          np_valid,
  input  logic [IW-1:0] np_target,
  output logic [IW-1:0] nxt_idx,
  output logic          list_end
);
  logic fwd_jump;

  assign fwd_jump = np_valid && (np_target > cur_idx);

  always_comb begin
    nxt_idx  = cur_idx + IW'(1);
    list_end = 1'b0;
    if (fwd_jump) begin
      nxt_idx = np_target;
      if (np_target > last_idx) list_end = 1'b1;
    end else if (cur_idx >= last_idx) begin
      list_end = 1'b1;
    end
  end
endmodule

// File: rtl/dlw_walker.sv
module dlw_walker #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    list_en,
  input  logic [N-1:0]  skip_iso,
  input  logic [N-1:0]  skip_int,
  input  logic [N-1:0]  skip_asy,
  input  logic [IW-1:0] last_iso,
  input  logic [IW-1:0] last_int,
  input  logic [IW-1:0] last_asy,
  output logic [1:0]    np_list,
  output logic [IW-1:0] np_idx,
  input  logic          np_valid,
  input  logic [IW-1:0] np_target,
  output logic          iss_valid,
  input  logic          iss_ready,
  output logic [1:0]    iss_list,
  output logic [IW-1:0] iss_idx,
  input  logic          done,
  output logic          pass_done
);
  import dlw_pkg::*;

  walk_st_t      st_q, st_d;
  list_t         lst_q, lst_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          pd_q, pd_d;

  logic          en_sel;
  logic [N-1:0]  skip_sel;
  logic [IW-1:0] last_sel;
  logic [IW-1:0] nxt_idx;
  logic          list_end;
  logic          step, next_list;

  dlw_list_sel #(.N(N)) u_sel (
    .sel      (lst_q),
    .list_en  (list_en),
    .skip_iso (skip_iso),
    .skip_int (skip_int),
    .skip_asy (skip_asy),
    .last_iso (last_iso),
    .last_int (last_int),
    .last_asy (last_asy),
    .en_sel   (en_sel),
    .skip_sel (skip_sel),
    .last_sel (last_sel)
  );

  dlw_advance #(.N(N)) u_adv (
    .cur_idx   (idx_q),
    .last_idx  (last_sel),
    .np_valid  (np_valid),
    .np_target (np_target),
    .nxt_idx   (nxt_idx),
    .list_end  (list_end)
  );

  always_comb begin
    st_d      = st_q;
    lst_d     = lst_q;
    idx_d     = idx_q;
    pd_d      = 1'b0;
    step      = 1'b0;
    next_list = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_EVAL;
          lst_d = LT_ISO;
          idx_d = '0;
        end
      end
      ST_EVAL: begin
        if (!en_sel)               next_list = 1'b1;
        else if (skip_sel[idx_q])  step      = 1'b1;
        else                       st_d      = ST_ISSUE;
      end
      ST_ISSUE: begin
        if (iss_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (done) step = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase

    if (step) begin
      if (list_end) begin
        next_list = 1'b1;
      end else begin
        idx_d = nxt_idx;
        st_d  = ST_EVAL;
      end
    end

    if (next_list) begin
      idx_d = '0;
      if (lst_q == LT_ASY) begin
        st_d = ST_IDLE;
        pd_d = 1'b1;
      end else begin
        lst_d = list_t'(2'(lst_q) + 2'd1);
        st_d  = ST_EVAL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      lst_q <= LT_ISO;
      idx_q <= '0;
      pd_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      lst_q <= lst_d;
      idx_q <= idx_d;
      pd_q  <= pd_d;
    end
  end

  assign np_list   = lst_q;
  assign np_idx    = idx_q;
  assign iss_valid = (st_q == ST_ISSUE);
  assign iss_list  = lst_q;
  assign iss_idx   = idx_q;
  assign pass_done = pd_q;
endmodule

// File: rtl/dlw_walker_chk.sv
module dlw_walker_chk #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  skip_iso,
  input logic [N-1:0]  skip_int,
  input logic [N-1:0]  skip_asy,
  input logic [IW-1:0] last_iso,
  input logic [IW-1:0] last_int,
  input logic [IW-1:0] last_asy,
  input logic          iss_valid,
  input logic          iss_ready,
  input logic [1:0]    iss_list,
  input logic [IW-1:0] iss_idx,
  input logic          done,
  input logic          pass_done
);
  logic          outst_q;
  logic          prev_v_q;
  logic [1:0]    prev_l_q;
  logic [IW-1:0] prev_i_q;
  logic          skip_bit;
  logic [IW-1:0] last_of;

  always_comb begin
    unique case (iss_list)
      2'd0:    begin skip_bit = skip_iso[iss_idx]; last_of = last_iso; end
      2'd1:    begin skip_bit = skip_int[iss_idx]; last_of = last_int; end
      2'd2:    begin skip_bit = skip_asy[iss_idx]; last_of = last_asy; end
      default: begin skip_bit = 1'b1;              last_of = '0;       end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q  <= 1'b0;
      prev_v_q <= 1'b0;
      prev_l_q <= '0;
      prev_i_q <= '0;
    end else begin
      if (iss_valid && iss_ready) outst_q <= 1'b1;
      else if (done)              outst_q <= 1'b0;
      if (pass_done) begin
        prev_v_q <= 1'b0;
      end else if (iss_valid && iss_ready) begin
        prev_v_q <= 1'b1;
        prev_l_q <= iss_list;
        prev_i_q <= iss_idx;
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_list) && $stable(iss_idx)));

  p_wait_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q |-> !iss_valid);

  p_no_skipped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !skip_bit);

  p_within_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (iss_idx <= last_of));

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && prev_v_q) |->
      ((iss_list > prev_l_q) || (iss_list == prev_l_q && iss_idx > prev_i_q)));

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> !pass_done);
endmodule

bind dlw_walker dlw_walker_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .skip_iso  (skip_iso),
  .skip_int  (skip_int),
  .skip_asy  (skip_asy),
  .last_iso  (last_iso),
  .last_int  (last_int),
  .last_asy  (last_asy),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .iss_list  (iss_list),
  .iss_idx   (iss_idx),
  .done      (done),
  .pass_done (pass_done)
);

// File: tb/dlw_walker_tb.sv
module dlw_walker_tb;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          start = 1'b0;
  logic [2:0]    list_en = 3'b111;
  logic [N-1:0]  skv [3];
  logic [IW-1:0] lst [3];
  logic          npv [3][N];
  logic [IW-1:0] npt [3][N];
  logic [1:0]    np_list;
  logic [IW-1:0] np_idx;
  logic          np_valid;
  logic [IW-1:0] np_target;
  logic          iss_valid;
  logic          iss_ready = 1'b0;
  logic [1:0]    iss_list;
  logic [IW-1:0] iss_idx;
  logic          done = 1'b0;
  logic          pass_done;

  int errors = 0;
  int checks = 0;
  int exp_l [64];
  int exp_i [64];
  int exp_n;
  int got_l [64];
  int got_i [64];
  int got_n;
  int seed = 32'h1d2c3b4a;

  always_comb begin
    np_valid  = 1'b0;
    np_target = '0;
    if (np_list < 2'd3) begin
      np_valid  = npv[np_list][np_idx];
      np_target = npt[np_list][np_idx];
    end
  end

  dlw_walker #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .list_en(list_en),
    .skip_iso(skv[0]), .skip_int(skv[1]), .skip_asy(skv[2]),
    .last_iso(lst[0]), .last_int(lst[1]), .last_asy(lst[2]),
    .np_list(np_list), .np_idx(np_idx), .np_valid(np_valid), .np_target(np_target),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_list(iss_list), .iss_idx(iss_idx),
    .done(done), .pass_done(pass_done)
  );

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h7fff;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Walk model built from the requirements
  function automatic void build_exp();
    exp_n = 0;
    for (int l = 0; l < 3; l++) begin
      if (list_en[l]) begin
        int  i   = 0;
        bit  fin = 0;
        while (!fin) begin
          if (!skv[l][i]) begin
            exp_l[exp_n] = l;
            exp_i[exp_n] = i;
            exp_n++;
          end
          if (npv[l][i] && int'(npt[l][i]) > i) begin
            if (int'(npt[l][i]) > int'(lst[l])) fin = 1;
            else i = int'(npt[l][i]);
          end else if (i >= int'(lst[l])) fin = 1;
          else i++;
        end
      end
    end
  endfunction

  task automatic clear_cfg();
    for (int l = 0; l < 3; l++) begin
      skv[l] = '0;
      lst[l] = 3'd7;
      for (int i = 0; i < N; i++) begin
        npv[l][i] = 1'b0;
        npt[l][i] = '0;
      end
    end
    list_en = 3'b111;
  endtask

  task automatic run_pass(input string tag, input int rdy_dly, input int done_dly);
    bit fin = 0;
    build_exp();
    got_n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int cyc = 0; cyc < 2000 && !fin; cyc++) begin
      if (pass_done) begin
        fin = 1;
      end else if (iss_valid) begin
        int l0 = int'(iss_list);
        int i0 = int'(iss_idx);
        if (got_n < 64) begin
          got_l[got_n] = l0;
          got_i[got_n] = i0;
        end
        got_n++;
        for (int k = 0; k < rdy_dly; k++) begin
          @(negedge clk);
          // R9: offer held while not ready
          chk(iss_valid && int'(iss_list) == l0 && int'(iss_idx) == i0,
              "R9 hold", int'(iss_idx), i0);
        end
        iss_ready = 1'b1;
        @(negedge clk);
        iss_ready = 1'b0;
        for (int k = 0; k < done_dly; k++) begin
          // R10: nothing offered before done
          chk(!iss_valid, "R10 wait", int'(iss_valid), 0);
          @(negedge clk);
        end
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        continue;
      end
      @(negedge clk);
    end
    // R11: pass completion seen
    chk(fin, {tag, " R11 pass_done"}, int'(fin), 1);
    @(negedge clk);
    chk(!pass_done, {tag, " R11 pulse width"}, int'(pass_done), 0);
    chk(got_n == exp_n, {tag, " count"}, got_n, exp_n);
    for (int k = 0; k < exp_n && k < got_n; k++) begin
      chk(got_l[k] == exp_l[k], {tag, " list"}, got_l[k], exp_l[k]);
      chk(got_i[k] == exp_i[k], {tag, " index"}, got_i[k], exp_i[k]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_cfg();
    repeat (3) @(negedge clk);
    // R1: idle after reset
    chk(!iss_valid, "R1 iss_valid", int'(iss_valid), 0);
    chk(!pass_done, "R1 pass_done", int'(pass_done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!iss_valid && !pass_done, "R1 idle without start", int'(iss_valid), 0);

    // R2 / R8: all lists, short last indices
    clear_cfg();
    lst[0] = 3'd2; lst[1] = 3'd0; lst[2] = 3'd4;
    run_pass("R2 R8 order", 0, 0);

    // R3: middle list disabled, then all disabled
    clear_cfg();
    list_en = 3'b101; lst[0] = 3'd1; lst[2] = 3'd1;
    run_pass("R3 disabled", 1, 2);
    list_en = 3'b000;
    run_pass("R3 none enabled", 0, 0);

    // R4: skipped entries, including the last one
    clear_cfg();
    skv[0] = 8'b1000_0101; skv[1] = 8'hff; skv[2] = 8'b0111_1110;
    run_pass("R4 skip", 2, 1);

    // R5: forward jumps, one from a skipped entry landing on last
    clear_cfg();
    lst[0] = 3'd6;
    npv[0][0] = 1'b1; npt[0][0] = 3'd3;
    skv[0][3] = 1'b1; npv[0][3] = 1'b1; npt[0][3] = 3'd6;
    npv[1][1] = 1'b1; npt[1][1] = 3'd7;
    run_pass("R5 jump", 0, 1);

    // R6: backward and self targets ignored
    clear_cfg();
    lst[1] = 3'd5;
    npv[1][2] = 1'b1; npt[1][2] = 3'd2;
    npv[1][4] = 1'b1; npt[1][4] = 3'd1;
    npv[1][5] = 1'b1; npt[1][5] = 3'd0;
    run_pass("R6 backward", 1, 0);

    // R7: target beyond last ends list
    clear_cfg();
    lst[0] = 3'd4; lst[2] = 3'd3;
    npv[0][1] = 1'b1; npt[0][1] = 3'd6;
    skv[2][0] = 1'b1; npv[2][0] = 1'b1; npt[2][0] = 3'd5;
    list_en = 3'b101;
    run_pass("R7 overshoot", 0, 0);

    // Sweep: every isochronous skip pattern with derived configuration
    for (int s = 0; s < 256; s++) begin
      skv[0] = 8'(s);
      skv[1] = 8'(rnd());
      skv[2] = 8'(rnd());
      for (int l = 0; l < 3; l++) begin
        lst[l] = 3'(rnd());
        for (int i = 0; i < N; i++) begin
          npv[l][i] = (rnd() % 3) == 0;
          npt[l][i] = 3'(rnd());
        end
      end
      list_en = ((s % 5) == 0) ? 3'(rnd()) : 3'b111;
      run_pass("R2 R4 R5 R6 R7 sweep", s % 3, (s >> 2) % 3);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule